// File: doc/BRIEF.md
# Program Counter and Stack Sequencer

This block owns the program counter and the stack pointer of a small byte-oriented processor core. It performs every control transfer: jumps, subroutine calls and returns, restarts to fixed vectors, loading the program counter from the HL register pair, and swapping HL with the two bytes on top of the stack. The decoder ahead of it issues one command per transfer. With each command it supplies the target address, the address of the following instruction, an optional condition code with the four status flags, a restart number and the current HL value.

Any command that must save or restore a return address, or exchange HL with the stack, runs as a short sequence of single-cycle accesses on a byte-wide memory port. That port uses a synchronous read: read data returns in the cycle after the read strobe. While a sequence runs, the block reports busy and ignores new commands. Every command that completes raises a one-cycle done pulse. Commands can be issued back to back, with a new one accepted in the same cycle as the previous done.

Top module: `pc_stack_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, pc_out is 0, sp_out equals the SP_INIT parameter, busy and done are 0, and neither mem_we nor mem_re is asserted.
- R2: An unconditional jump (cmd_op 0, cmd_cond_en 0) loads pc_out with cmd_target, makes no memory access, and raises done in the cycle after it is accepted.
- R3: When cmd_cond_en is 1, a jump (op 0) or call (op 1) is taken only if its condition holds. The conditions are: code 000 Z=0, 001 Z=1, 010 CY=0, 011 CY=1, 100 P=0, 101 P=1, 110 S=0, 111 S=1. If the condition is false, pc_out becomes next_pc, done rises in the following cycle, and there is no memory access and no change to the stack pointer.
- R4: A taken call (op 1) first decrements SP and writes the high byte of next_pc at the new SP. It then decrements SP again and writes the low byte. After that, pc_out becomes cmd_target with sp_out = SP-2, and done is seen three cycles after acceptance.
- R5: A return (op 2) reads the low byte of the new PC at SP and the high byte at SP+1. It then sets sp_out to SP+2, and done is seen four cycles after acceptance.
- R6: A restart (op 3) pushes next_pc in the same way as a call and loads pc_out with rst_num multiplied by 8 (0000h to 0038h).
- R7: Load-from-HL (op 4) sets pc_out to hl_in, with H in bits 15:8 and L in bits 7:0. It makes no memory access, and done follows in the next cycle.
- R8: Swap (op 5) exchanges L with the byte at SP and H with the byte at SP+1, leaving SP unchanged. The new HL appears on hl_out, qualified by a one-cycle hl_we that coincides with done, five cycles after acceptance.
- R9: A cmd_valid received while busy is 1 is ignored. Op codes 6 and 7 are ignored too: they produce no done, no memory access and no change to the PC.
- R10: The memory port makes at most one access per cycle, never reads and writes in the same cycle, and is active only while busy is 1.
- R11: done lasts one cycle for each completed command, busy is 0 during that cycle, pc_out changes only in a cycle where done is 1, and a command presented in the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | 0 jump, 1 call, 2 return, 3 restart, 4 load PC from HL, 5 swap HL with stack top, 6/7 ignored |
| cmd_cond_en | input | 1 | Jump/call is conditional on cmd_cond |
| cmd_cond | input | 3 | Condition code (see R3) |
| cmd_target | input | 16 | Jump or call destination |
| next_pc | input | 16 | Address of the following instruction |
| rst_num | input | 3 | Restart number 0..7 |
| flag_s | input | 1 | Sign flag |
| flag_z | input | 1 | Zero flag |
| flag_p | input | 1 | Parity flag (1 = even) |
| flag_cy | input | 1 | Carry flag |
| hl_in | input | 16 | Current HL pair |
| mem_addr | output | 16 | Memory byte address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe (data returns next cycle) |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data |
| pc_out | output | 16 | Program counter |
| sp_out | output | 16 | Stack pointer |
| hl_out | output | 16 | New HL after a swap |
| hl_we | output | 1 | hl_out valid, one cycle |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Command completed, one cycle |

## Verification
Two functions can fall in the same cycle: the done pulse that closes one command, and the acceptance of the next command. A command that arrives while a sequence is still running must instead be dropped. The bench issues every command as soon as it sees done, so each follow-up is presented in the completion cycle of the one before. Part of this stream is a jump offered immediately after a call's done, which must land one cycle later. The bench also drives a jump in the middle of a call's push sequence and checks that the call's target, its stack contents and its final SP are all left untouched.

// File: rtl/pcs_pkg.sv
package pcs_pkg;
  localparam logic [2:0] OP_JUMP    = 3'd0;
  localparam logic [2:0] OP_CALL    = 3'd1;
  localparam logic [2:0] OP_RETURN  = 3'd2;
  localparam logic [2:0] OP_RESTART = 3'd3;
  localparam logic [2:0] OP_HL2PC   = 3'd4;
  localparam logic [2:0] OP_SWAP    = 3'd5;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PUSH_HI,
    ST_PUSH_LO,
    ST_POP_LO,
    ST_POP_HI,
    ST_POP_END,
    ST_SW_RD_LO,
    ST_SW_RD_HI,
    ST_SW_WR_LO,
    ST_SW_WR_HI
  } seq_state_t;
endpackage

// File: rtl/pcs_cond_eval.sv
module pcs_cond_eval (
  input  logic [2:0] code,
  input  logic       flag_s,
  input  logic       flag_z,
  input  logic       flag_p,
  input  logic       flag_cy,
  output logic       pass
);
  logic sel;
  // code[2:1] picks the flag, code[0] picks the polarity that passes
  always_comb begin
    case (code[2:1])
      2'b00:   sel = flag_z;
      2'b01:   sel = flag_cy;
      2'b10:   sel = flag_p;
      default: sel = flag_s;
    endcase
  end
  assign pass = code[0] ? sel : ~sel;
endmodule

// File: rtl/pcs_vector.sv
module pcs_vector #(
  parameter int NUM_W   = 3,
  parameter int SHIFT   = 3,
  parameter int ADDR_W  = 16
) (
  input  logic [NUM_W-1:0]  num,
  output logic [ADDR_W-1:0] vec
);
  assign vec = ADDR_W'(num) << SHIFT;
endmodule

// File: rtl/pc_stack_seq.sv
module pc_stack_seq
  import pcs_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int RST_W     = 3,
  parameter int VEC_SHIFT = 3,
  parameter logic [2*DATA_W-1:0] SP_INIT = '0,
  localparam int ADDR_W   = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic              cmd_cond_en,
  input  logic [2:0]        cmd_cond,
  input  logic [ADDR_W-1:0] cmd_target,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic [RST_W-1:0]  rst_num,
  input  logic              flag_s,
  input  logic              flag_z,
  input  logic              flag_p,
  input  logic              flag_cy,
  input  logic [ADDR_W-1:0] hl_in,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] pc_out,
  output logic [ADDR_W-1:0] sp_out,
  output logic [ADDR_W-1:0] hl_out,
  output logic              hl_we,
  output logic              busy,
  output logic              done
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] TWO = ADDR_W'(2);

  seq_state_t        st_q;
  logic [ADDR_W-1:0] pc_q, sp_q, tgt_q, hl_q, hl_out_q, addr_q;
  logic [DATA_W-1:0] ret_lo_q, lo_q, wdata_q;
  logic              we_q, re_q, done_q, hl_we_q;
  logic              cond_ok, go;
  logic [ADDR_W-1:0] vec;

  pcs_cond_eval u_cond (
    .code(cmd_cond), .flag_s(flag_s), .flag_z(flag_z),
    .flag_p(flag_p), .flag_cy(flag_cy), .pass(cond_ok)
  );

  pcs_vector #(.NUM_W(RST_W), .SHIFT(VEC_SHIFT), .ADDR_W(ADDR_W)) u_vec (
    .num(rst_num), .vec(vec)
  );

  assign go = !cmd_cond_en || cond_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      pc_q     <= '0;
      sp_q     <= SP_INIT;
      tgt_q    <= '0;
      hl_q     <= '0;
      hl_out_q <= '0;
      addr_q   <= '0;
      ret_lo_q <= '0;
      lo_q     <= '0;
      wdata_q  <= '0;
      we_q     <= 1'b0;
      re_q     <= 1'b0;
      done_q   <= 1'b0;
      hl_we_q  <= 1'b0;
    end else begin
      we_q    <= 1'b0;
      re_q    <= 1'b0;
      done_q  <= 1'b0;
      hl_we_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (cmd_valid) begin
            case (cmd_op)
              OP_JUMP: begin
                pc_q   <= go ? cmd_target : next_pc;
                done_q <= 1'b1;
              end
              OP_CALL, OP_RESTART: begin
                if (cmd_op == OP_RESTART || go) begin
                  tgt_q    <= (cmd_op == OP_RESTART) ? vec : cmd_target;
                  ret_lo_q <= next_pc[DATA_W-1:0];
                  sp_q     <= sp_q - ONE;
                  addr_q   <= sp_q - ONE;
                  wdata_q  <= next_pc[ADDR_W-1:DATA_W];
                  we_q     <= 1'b1;
                  st_q     <= ST_PUSH_HI;
                end else begin
                  pc_q   <= next_pc;
                  done_q <= 1'b1;
                end
              end
              OP_RETURN: begin
                addr_q <= sp_q;
                re_q   <= 1'b1;
                st_q   <= ST_POP_LO;
              end
              OP_HL2PC: begin
                pc_q   <= hl_in;
                done_q <= 1'b1;
              end
              OP_SWAP: begin
                hl_q   <= hl_in;
                addr_q <= sp_q;
                re_q   <= 1'b1;
                st_q   <= ST_SW_RD_LO;
              end
              default: ;
            endcase
          end
        end
        ST_PUSH_HI: begin
          sp_q    <= sp_q - ONE;
          addr_q  <= sp_q - ONE;
          wdata_q <= ret_lo_q;
          we_q    <= 1'b1;
          st_q    <= ST_PUSH_LO;
        end
        ST_PUSH_LO: begin
          pc_q   <= tgt_q;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_POP_LO: begin
          addr_q <= sp_q + ONE;
          re_q   <= 1'b1;
          st_q   <= ST_POP_HI;
        end
        ST_POP_HI: begin
          lo_q <= mem_rdata;
          st_q <= ST_POP_END;
        end
        ST_POP_END: begin
          pc_q   <= {mem_rdata, lo_q};
          sp_q   <= sp_q + TWO;
          done_q <= 1'b1;
          st_q   <= ST_IDLE;
        end
        ST_SW_RD_LO: begin
          addr_q <= sp_q + ONE;
          re_q   <= 1'b1;
          st_q   <= ST_SW_RD_HI;
        end
        ST_SW_RD_HI: begin
          lo_q    <= mem_rdata;
          addr_q  <= sp_q;
          wdata_q <= hl_q[DATA_W-1:0];
          we_q    <= 1'b1;
          st_q    <= ST_SW_WR_LO;
        end
        ST_SW_WR_LO: begin
          hl_out_q <= {mem_rdata, lo_q};
          addr_q   <= sp_q + ONE;
          wdata_q  <= hl_q[ADDR_W-1:DATA_W];
          we_q     <= 1'b1;
          st_q     <= ST_SW_WR_HI;
        end
        ST_SW_WR_HI: begin
          hl_we_q <= 1'b1;
          done_q  <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign mem_addr  = addr_q;
  assign mem_we    = we_q;
  assign mem_re    = re_q;
  assign mem_wdata = wdata_q;
  assign pc_out    = pc_q;
  assign sp_out    = sp_q;
  assign hl_out    = hl_out_q;
  assign hl_we     = hl_we_q;
  assign done      = done_q;
  assign busy      = (st_q != ST_IDLE);
endmodule

// File: rtl/pcs_checker.sv
module pcs_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_we,
  input logic              mem_re,
  input logic              busy,
  input logic              done,
  input logic              hl_we,
  input logic [ADDR_W-1:0] pc_out,
  input logic [ADDR_W-1:0] sp_out
);
  assert_one_access_R10: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  assert_access_busy_R10: assert property (@(posedge clk) disable iff (rst)
    (mem_we || mem_re) |-> busy);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_pc_on_done_R11: assert property (@(posedge clk) disable iff (rst)
    !$stable(pc_out) |-> done);

  assert_sp_in_seq_R4: assert property (@(posedge clk) disable iff (rst)
    !$stable(sp_out) |-> (busy || done));

  assert_hl_with_done_R8: assert property (@(posedge clk) disable iff (rst)
    hl_we |-> done);
endmodule

bind pc_stack_seq pcs_checker #(.ADDR_W(ADDR_W)) u_pcs_checker (
  .clk(clk), .rst(rst), .mem_we(mem_we), .mem_re(mem_re), .busy(busy),
  .done(done), .hl_we(hl_we), .pc_out(pc_out), .sp_out(sp_out)
);

// File: tb/pc_stack_seq_bench.sv
`timescale 1ns/1ps
module pc_stack_seq_bench;
  logic        clk = 1'b0;
  logic        rst;
  logic        cmd_valid, cmd_cond_en;
  logic [2:0]  cmd_op, cmd_cond, rst_num;
  logic [15:0] cmd_target, next_pc, hl_in;
  logic        flag_s, flag_z, flag_p, flag_cy;
  logic [15:0] mem_addr, pc_out, sp_out, hl_out;
  logic        mem_we, mem_re, hl_we, busy, done;
  logic [7:0]  mem_wdata, mem_rdata;

  int checks = 0;
  int fails  = 0;
  int acc_cnt = 0;
  int port_err = 0;
  int cycles = 0;
  logic [7:0] mem [256];

  always #10 clk = ~clk;

  pc_stack_seq #(.SP_INIT(16'h0080)) u_pc_stack_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_cond_en(cmd_cond_en), .cmd_cond(cmd_cond), .cmd_target(cmd_target),
    .next_pc(next_pc), .rst_num(rst_num), .flag_s(flag_s), .flag_z(flag_z),
    .flag_p(flag_p), .flag_cy(flag_cy), .hl_in(hl_in), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_re(mem_re), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .pc_out(pc_out), .sp_out(sp_out), .hl_out(hl_out),
    .hl_we(hl_we), .busy(busy), .done(done)
  );

  // byte memory with synchronous read, and a port monitor for R10
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_re) mem_rdata <= mem[mem_addr[7:0]];
    if (!rst && (mem_we || mem_re)) acc_cnt <= acc_cnt + 1;
    if (!rst && ((mem_we && mem_re) || ((mem_we || mem_re) && !busy)))
      port_err <= port_err + 1;
  end

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [2:0] op, input logic cen, input logic [2:0] cc,
                      input logic [15:0] tgt, input logic [15:0] nxt,
                      input logic [2:0] n, input logic [15:0] hl);
    cmd_valid = 1'b1; cmd_op = op; cmd_cond_en = cen; cmd_cond = cc;
    cmd_target = tgt; next_pc = nxt; rst_num = n; hl_in = hl;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
    end
  endtask

  function automatic logic cond_true(input logic [2:0] c, input logic s,
                                     input logic z, input logic p, input logic cy);
    case (c)
      3'd0: return !z;
      3'd1: return z;
      3'd2: return !cy;
      3'd3: return cy;
      3'd4: return !p;
      3'd5: return p;
      3'd6: return !s;
      default: return s;
    endcase
  endfunction

  task automatic t_reset();
    check("R1 pc", pc_out, 16'h0000);
    check("R1 sp", sp_out, 16'h0080);
    check("R1 busy", {15'd0, busy}, 16'd0);
    check("R1 done", {15'd0, done}, 16'd0);
    check("R1 mem strobes", {14'd0, mem_we, mem_re}, 16'd0);
  endtask

  task automatic t_jump();
    int lat; int a0;
    a0 = acc_cnt;
    send(3'd0, 1'b0, 3'd0, 16'h1234, 16'h0101, 3'd0, 16'h0);
    wait_done(lat);
    check("R2 latency", 16'(lat), 16'd1);
    check("R2 pc", pc_out, 16'h1234);
    check("R2 no mem", 16'(acc_cnt - a0), 16'd0);
  endtask

  task automatic t_cond();
    int lat; int a0; logic exp_t;
    a0 = acc_cnt;
    for (int c = 0; c < 8; c++) begin
      for (int f = 0; f < 16; f++) begin
        {flag_s, flag_z, flag_p, flag_cy} = 4'(f);
        exp_t = cond_true(3'(c), flag_s, flag_z, flag_p, flag_cy);
        send(3'd0, 1'b1, 3'(c), 16'hA000 + 16'(c), 16'h5000 + 16'(f), 3'd0, 16'h0);
        wait_done(lat);
        check("R3 cond jump pc", pc_out,
              exp_t ? 16'hA000 + 16'(c) : 16'h5000 + 16'(f));
      end
    end
    // false conditional call: no push, SP untouched
    {flag_s, flag_z, flag_p, flag_cy} = 4'b0000;
    send(3'd1, 1'b1, 3'd3, 16'h4444, 16'h0777, 3'd0, 16'h0);
    wait_done(lat);
    check("R3 false call latency", 16'(lat), 16'd1);
    check("R3 false call pc", pc_out, 16'h0777);
    check("R3 false call sp", sp_out, 16'h0080);
    check("R3 no mem", 16'(acc_cnt - a0), 16'd0);
  endtask

  task automatic t_call_ret();
    int lat; int a0;
    a0 = acc_cnt;
    flag_cy = 1'b1;
    send(3'd1, 1'b1, 3'd3, 16'h4000, 16'h2001, 3'd0, 16'h0);
    wait_done(lat);
    check("R4 latency", 16'(lat), 16'd3);
    check("R4 pc", pc_out, 16'h4000);
    check("R4 sp", sp_out, 16'h007E);
    check("R4 high byte at SP-1", {8'd0, mem[8'h7F]}, 16'h0020);
    check("R4 low byte at SP-2", {8'd0, mem[8'h7E]}, 16'h0001);
    check("R4 two writes", 16'(acc_cnt - a0), 16'd2);
    send(3'd2, 1'b0, 3'd0, 16'h0, 16'h4001, 3'd0, 16'h0);
    wait_done(lat);
    check("R5 latency", 16'(lat), 16'd4);
    check("R5 pc", pc_out, 16'h2001);
    check("R5 sp", sp_out, 16'h0080);
  endtask

  task automatic t_restart(input logic [2:0] n);
    int lat;
    send(3'd3, 1'b0, 3'd0, 16'hFFFF, 16'h3456, n, 16'h0);
    wait_done(lat);
    check("R6 latency", 16'(lat), 16'd3);
    check("R6 vector", pc_out, {10'd0, n, 3'd0});
    check("R6 sp", sp_out, 16'h007E);
    check("R6 pushed", {mem[8'h7F], mem[8'h7E]}, 16'h3456);
    send(3'd2, 1'b0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
    wait_done(lat);
    check("R6 return", pc_out, 16'h3456);
  endtask

  task automatic t_hl2pc();
    int lat; int a0;
    a0 = acc_cnt;
    send(3'd4, 1'b0, 3'd0, 16'h1111, 16'h2222, 3'd0, 16'h6000);
    wait_done(lat);
    check("R7 latency", 16'(lat), 16'd1);
    check("R7 pc", pc_out, 16'h6000);
    check("R7 no mem", 16'(acc_cnt - a0), 16'd0);
  endtask

  task automatic t_swap();
    int lat;
    mem[8'h80] = 8'h60;
    mem[8'h81] = 8'h50;
    send(3'd5, 1'b0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h3040);
    wait_done(lat);
    check("R8 latency", 16'(lat), 16'd5);
    check("R8 hl_we with done", {15'd0, hl_we}, 16'd1);
    check("R8 new hl", hl_out, 16'h5060);
    check("R8 sp unchanged", sp_out, 16'h0080);
    check("R8 stack now HL", {mem[8'h81], mem[8'h80]}, 16'h3040);
    check("R8 pc unchanged", pc_out, 16'h6000);
  endtask

  task automatic t_busy_ignore();
    int lat;
    send(3'd1, 1'b0, 3'd0, 16'h0ABC, 16'h0123, 3'd0, 16'h0);
    // busy now: offer a jump that must be dropped
    check("R9 busy during push", {15'd0, busy}, 16'd1);
    send(3'd0, 1'b0, 3'd0, 16'h7777, 16'h0, 3'd0, 16'h0);
    wait_done(lat);
    check("R9 call target kept", pc_out, 16'h0ABC);
    check("R9 sp kept", sp_out, 16'h007E);
    check("R9 stack kept", {mem[8'h7F], mem[8'h7E]}, 16'h0123);
    @(negedge clk);
    check("R9 no late done", {15'd0, done}, 16'd0);
    check("R9 no late jump", pc_out, 16'h0ABC);
    send(3'd6, 1'b0, 3'd0, 16'h5555, 16'h5555, 3'd0, 16'h5555);
    send(3'd7, 1'b0, 3'd0, 16'h5555, 16'h5555, 3'd0, 16'h5555);
    for (int i = 0; i < 3; i++) begin
      check("R9 reserved no done", {15'd0, done, busy}, 16'd0);
      @(negedge clk);
    end
    check("R9 reserved pc", pc_out, 16'h0ABC);
    send(3'd2, 1'b0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
    wait_done(lat);
    check("R9 return after", pc_out, 16'h0123);
  endtask

  task automatic t_back2back();
    int lat;
    send(3'd1, 1'b0, 3'd0, 16'h0F00, 16'h0E01, 3'd0, 16'h0);
    wait_done(lat);
    check("R11 done idle", {15'd0, busy}, 16'd0);
    // new command in the very cycle done is high
    send(3'd0, 1'b0, 3'd0, 16'h0D00, 16'h0, 3'd0, 16'h0);
    check("R11 accepted in done cycle", {15'd0, done}, 16'd1);
    check("R11 pc", pc_out, 16'h0D00);
    @(negedge clk);
    check("R11 single pulse", {15'd0, done}, 16'd0);
    send(3'd2, 1'b0, 3'd0, 16'h0, 16'h0, 3'd0, 16'h0);
    wait_done(lat);
    check("R11 return pc", pc_out, 16'h0E01);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    rst = 1'b1; cmd_valid = 1'b0; cmd_op = 3'd0; cmd_cond_en = 1'b0;
    cmd_cond = 3'd0; cmd_target = '0; next_pc = '0; rst_num = '0; hl_in = '0;
    {flag_s, flag_z, flag_p, flag_cy} = 4'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_reset();
    t_jump();
    t_cond();
    t_call_ret();
    t_restart(3'd6);
    t_restart(3'd7);
    t_restart(3'd0);
    t_hl2pc();
    t_swap();
    t_busy_ignore();
    t_back2back();
    repeat (2) @(negedge clk);
    check("R10 port discipline errors", 16'(port_err), 16'd0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles == 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule